// File: doc/BRIEF.md
# Dual-CPU Memory Mapper Controller

This block sits beside a main processor that shares part of its RAM with a second, subordinate processor. It decodes a small group of I/O ports at the top of the main CPU's port space. Through those ports the main CPU chooses one of four memory maps and one of four ROM states, and it controls the sub-CPU's reset and bus-request lines. Reading the control port returns the sub-CPU's ready and acknowledge levels.

On every memory cycle the top three main-CPU address bits pick one of eight 8 KB windows. The block maps each window either to a ROM (the boot ROM, or the BASIC ROM in one of two strap-selected forms) or to one bank of one of four DRAM blocks. It drives remapped bank address bits and one active-low strobe or select for the chosen target. Selects are gated by the memory request, so nothing is driven outside a memory cycle.

The registers change only on the rising edge of the I/O write strobe during an I/O cycle. The remapping logic is purely combinational.

Top module: `mapper_ctl`

## Requirements
- R1: `io_sel_n` is 0 exactly while `io_cycle` is 1 and `port_addr` is in FCh..FFh. Otherwise it is 1.
- R2: After reset, `sub_reset_n`=0 and `sub_busreq_n`=1. The ROM state is boot (0) and the map is 0, so a read of port FDh returns 00h and a read of port FEh returns 00h.
- R3: A write to port FDh sets the sub-CPU run flag from data bit 7 (`sub_reset_n` follows it) and the ROM state from bits 1:0. The states are 0=boot, 1=RAM only, 2=BASIC, 3=RAM only. Writing 80h releases the sub-CPU.
- R4: A write to port FCh sets the bus-request flag from data bit 1. `sub_busreq_n` is its inverse, so writing 02h asserts the request and writing 00h withdraws it at the end of the command cycle.
- R5: A register loads only at the first clock edge of a write strobe (`io_wr` rising while `io_cycle`=1). Data changed while the strobe is held is not loaded. Writes to port FFh or to ports outside FCh..FFh change nothing.
- R6: An I/O read returns data on `cpu_dout` as follows: FCh gives {6'b0, `sub_ack`, `sub_ready`}, FDh gives {run, 5'b0, rom state}, FEh gives {6'b0, map}. Any other port, or no read, gives 00h.
- R7: A write to port FEh sets the map select from data bits 1:0.
- R8: For a RAM window w (`cpu_a_hi`), the DRAM block and bank depend on the map. In maps 0 and 1 the block is A and the bank is w. In map 2, w<4 goes to block A and w>=4 to block B, with bank w. In map 3, w<4 goes to block C and w>=4 to block D, with bank w XOR 4. `dram_a_hi` carries the bank.
- R9: `ipl_cs_n` is 0 only when `mreq`=1, the map is 0, the ROM state is boot and w=0.
- R10: In map 0 with the ROM state BASIC, windows 0..3 are ROM. With `rom32_sel`=1, `basic32_cs_n` is 0. With `rom32_sel`=0, `eprom_cs_n[w]` is 0. In any other state those selects stay 1.
- R11: Every window not claimed by R9 or R10 drives `ras_n[block]` low during `mreq` (bit 0=A, 1=B, 2=C, 3=D).
- R12: With `mreq`=0 all strobes and selects are 1. At most one of them is 0 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| io_cycle | input | 1 | Main CPU I/O cycle in progress |
| io_wr | input | 1 | I/O write strobe, active high |
| io_rd | input | 1 | I/O read strobe, active high |
| port_addr | input | 8 | Low byte of I/O port address |
| cpu_din | input | 8 | Data written by main CPU |
| cpu_dout | output | 8 | Data returned on I/O read |
| io_sel_n | output | 1 | Active-low select for the block's own ports |
| mreq | input | 1 | Memory request, active high |
| cpu_a_hi | input | 3 | Main CPU address bits 15..13 |
| rom32_sel | input | 1 | Strap: 1 = single 32 KB BASIC ROM, 0 = four 8 KB EPROMs |
| dram_a_hi | output | 3 | Remapped DRAM bank address bits |
| ras_n | output | 4 | Row strobes for DRAM blocks A..D |
| ipl_cs_n | output | 1 | Boot ROM select |
| basic32_cs_n | output | 1 | 32 KB BASIC ROM select |
| eprom_cs_n | output | 4 | 8 KB BASIC EPROM selects A..D |
| sub_reset_n | output | 1 | Sub-CPU reset, low holds it halted |
| sub_busreq_n | output | 1 | Bus request to sub-CPU, active low |
| sub_ready | input | 1 | Ready level from sub-CPU |
| sub_ack | input | 1 | Bus acknowledge from sub-CPU |

## Verification
A port write that changes the ROM state can arrive while a memory cycle to window 0 is still in progress. In that case the register update and the select decode meet in the same cycle. The bench holds `mreq` on window 0 in the boot state and writes 02h to port FDh. It judges that the boot select stays low until the loading edge and that only the BASIC select is low from then on. A held write strobe with data changed mid-pulse tests the edge-only loading through readback.

// File: rtl/mmc_pkg.sv
package mmc_pkg;
    localparam int DATA_W   = 8;
    localparam int PORT_W   = 8;
    localparam int WIN_W    = 3;
    localparam int BLK_N    = 4;
    localparam int EPROM_N  = 4;
    localparam int BLK_W    = $clog2(BLK_N);
    localparam int MAP_W    = 2;
    localparam int WIN_HALF = 4;

    localparam logic [PORT_W-1:0] PORT_CTL  = 8'hFC;
    localparam logic [PORT_W-1:0] PORT_MODE = 8'hFD;
    localparam logic [PORT_W-1:0] PORT_MAP  = 8'hFE;
    localparam logic [PORT_W-3:0] PORT_GRP  = 6'h3F;

    typedef enum logic [1:0] {
        SD_BOOT  = 2'd0,
        SD_RAM1  = 2'd1,
        SD_BASIC = 2'd2,
        SD_RAM3  = 2'd3
    } rom_state_e;

    typedef enum logic [1:0] {
        TGT_RAM   = 2'd0,
        TGT_IPL   = 2'd1,
        TGT_BASIC = 2'd2
    } target_e;

    typedef struct packed {
        target_e          tgt;
        logic [BLK_W-1:0] blk;
        logic [WIN_W-1:0] bank;
    } win_map_t;

    // Window lookup: ROM claims first, then per-map DRAM placement.
    function automatic win_map_t lookup(input logic [MAP_W-1:0] map,
                                        input rom_state_e       sd,
                                        input logic [WIN_W-1:0] w);
        win_map_t r;
        logic     upper;
        upper  = (w >= WIN_W'(WIN_HALF));
        r.tgt  = TGT_RAM;
        r.blk  = '0;
        r.bank = w;
        if (map == 2'd0 && sd == SD_BOOT && w == '0)
            r.tgt = TGT_IPL;
        else if (map == 2'd0 && sd == SD_BASIC && !upper)
            r.tgt = TGT_BASIC;
        else begin
            unique case (map)
                2'd0, 2'd1: r.blk = BLK_W'(0);
                2'd2:       r.blk = upper ? BLK_W'(1) : BLK_W'(0);
                default: begin
                    r.blk  = upper ? BLK_W'(3) : BLK_W'(2);
                    r.bank = w ^ WIN_W'(WIN_HALF);
                end
            endcase
        end
        return r;
    endfunction
endpackage

// File: rtl/mmc_port_regs.sv
module mmc_port_regs
    import mmc_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int PW = PORT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          io_cycle,
    input  logic          io_wr,
    input  logic          io_rd,
    input  logic [PW-1:0] port_addr,
    input  logic [DW-1:0] din,
    input  logic          sub_ready,
    input  logic          sub_ack,
    output logic          io_sel_n,
    output logic [DW-1:0] dout,
    output rom_state_e    rom_state,
    output logic [MAP_W-1:0] map_sel,
    output logic          sub_run,
    output logic          bus_req
);
    logic wr_q;
    logic grp_hit;
    logic wr_edge;

    assign grp_hit  = io_cycle && (port_addr[PW-1:2] == PORT_GRP);
    assign io_sel_n = !grp_hit;
    assign wr_edge  = io_cycle && io_wr && !wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q      <= 1'b0;
            sub_run   <= 1'b0;
            bus_req   <= 1'b0;
            rom_state <= SD_BOOT;
            map_sel   <= '0;
        end else begin
            wr_q <= io_wr;
            if (wr_edge) begin
                unique case (port_addr)
                    PORT_CTL:  bus_req <= din[1];
                    PORT_MODE: begin
                        sub_run   <= din[DW-1];
                        rom_state <= rom_state_e'(din[1:0]);
                    end
                    PORT_MAP:  map_sel <= din[MAP_W-1:0];
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        dout = '0;
        if (io_cycle && io_rd) begin
            unique case (port_addr)
                PORT_CTL:  dout = {{(DW-2){1'b0}}, sub_ack, sub_ready};
                PORT_MODE: dout = {sub_run, {(DW-3){1'b0}}, rom_state};
                PORT_MAP:  dout = {{(DW-MAP_W){1'b0}}, map_sel};
                default:   dout = '0;
            endcase
        end
    end
endmodule

// File: rtl/mmc_remap.sv
module mmc_remap
    import mmc_pkg::*;
#(
    parameter int WW = WIN_W
) (
    input  logic [MAP_W-1:0] map_sel,
    input  rom_state_e       rom_state,
    input  logic [WW-1:0]    win,
    output win_map_t         wmap
);
    always_comb wmap = lookup(map_sel, rom_state, win);
endmodule

// File: rtl/mmc_select.sv
module mmc_select
    import mmc_pkg::*;
#(
    parameter int NB = BLK_N,
    parameter int NE = EPROM_N,
    parameter int WW = WIN_W
) (
    input  logic          mreq,
    input  logic          rom32_sel,
    input  logic [WW-1:0] win,
    input  win_map_t      wmap,
    output logic [WW-1:0] dram_a_hi,
    output logic [NB-1:0] ras_n,
    output logic          ipl_cs_n,
    output logic          basic32_cs_n,
    output logic [NE-1:0] eprom_cs_n
);
    localparam int EW = $clog2(NE);

    logic is_ram;
    logic is_basic;

    assign is_ram       = mreq && (wmap.tgt == TGT_RAM);
    assign is_basic     = mreq && (wmap.tgt == TGT_BASIC);
    assign ipl_cs_n     = !(mreq && (wmap.tgt == TGT_IPL));
    assign basic32_cs_n = !(is_basic && rom32_sel);
    assign dram_a_hi    = wmap.bank;

    for (genvar b = 0; b < NB; b++) begin : g_ras
        assign ras_n[b] = !(is_ram && (wmap.blk == BLK_W'(b)));
    end

    for (genvar e = 0; e < NE; e++) begin : g_eprom
        assign eprom_cs_n[e] = !(is_basic && !rom32_sel && (win[EW-1:0] == EW'(e)));
    end
endmodule

// File: rtl/mapper_ctl.sv
module mapper_ctl
    import mmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             io_cycle,
    input  logic             io_wr,
    input  logic             io_rd,
    input  logic [PORT_W-1:0] port_addr,
    input  logic [DATA_W-1:0] cpu_din,
    output logic [DATA_W-1:0] cpu_dout,
    output logic             io_sel_n,
    input  logic             mreq,
    input  logic [WIN_W-1:0] cpu_a_hi,
    input  logic             rom32_sel,
    output logic [WIN_W-1:0] dram_a_hi,
    output logic [BLK_N-1:0] ras_n,
    output logic             ipl_cs_n,
    output logic             basic32_cs_n,
    output logic [EPROM_N-1:0] eprom_cs_n,
    output logic             sub_reset_n,
    output logic             sub_busreq_n,
    input  logic             sub_ready,
    input  logic             sub_ack
);
    rom_state_e       rom_state;
    logic [MAP_W-1:0] map_sel;
    logic             sub_run;
    logic             bus_req;
    win_map_t         wmap;

    mmc_port_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .io_cycle  (io_cycle),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .port_addr (port_addr),
        .din       (cpu_din),
        .sub_ready (sub_ready),
        .sub_ack   (sub_ack),
        .io_sel_n  (io_sel_n),
        .dout      (cpu_dout),
        .rom_state (rom_state),
        .map_sel   (map_sel),
        .sub_run   (sub_run),
        .bus_req   (bus_req)
    );

    mmc_remap u_remap (
        .map_sel   (map_sel),
        .rom_state (rom_state),
        .win       (cpu_a_hi),
        .wmap      (wmap)
    );

    mmc_select u_sel (
        .mreq         (mreq),
        .rom32_sel    (rom32_sel),
        .win          (cpu_a_hi),
        .wmap         (wmap),
        .dram_a_hi    (dram_a_hi),
        .ras_n        (ras_n),
        .ipl_cs_n     (ipl_cs_n),
        .basic32_cs_n (basic32_cs_n),
        .eprom_cs_n   (eprom_cs_n)
    );

    assign sub_reset_n  = sub_run;
    assign sub_busreq_n = !bus_req;
endmodule

// File: rtl/mmc_checker.sv
module mmc_checker
    import mmc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              io_cycle,
    input logic [PORT_W-1:0] port_addr,
    input logic              io_sel_n,
    input logic              mreq,
    input logic [BLK_N-1:0]  ras_n,
    input logic              ipl_cs_n,
    input logic              basic32_cs_n,
    input logic [EPROM_N-1:0] eprom_cs_n,
    input logic              sub_reset_n,
    input logic              sub_busreq_n,
    input logic [1:0]        rom_state,
    input logic [MAP_W-1:0]  map_sel
);
    a_r1_port_select: assert property (@(posedge clk) disable iff (rst)
        (io_cycle && port_addr[PORT_W-1:2] == PORT_GRP) |-> !io_sel_n);

    a_r1_idle_select: assert property (@(posedge clk) disable iff (rst)
        !io_cycle |-> io_sel_n);

    a_r2_reset_state: assert property (@(posedge clk)
        rst |=> (!sub_reset_n && sub_busreq_n && rom_state == 2'd0 && map_sel == '0));

    a_r5_no_load_idle: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(io_cycle)) |->
            ($stable(rom_state) && $stable(map_sel) && $stable(sub_reset_n) && $stable(sub_busreq_n)));

    a_r9_ipl_gate: assert property (@(posedge clk) disable iff (rst)
        !ipl_cs_n |-> (mreq && rom_state == 2'd0 && map_sel == '0));

    a_r10_basic_gate: assert property (@(posedge clk) disable iff (rst)
        (!basic32_cs_n || !(&eprom_cs_n)) |-> (mreq && rom_state == 2'd2 && map_sel == '0));

    a_r12_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0({~ras_n, ~ipl_cs_n, ~basic32_cs_n, ~eprom_cs_n}));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !mreq |-> (&ras_n && ipl_cs_n && basic32_cs_n && &eprom_cs_n));
endmodule

bind mapper_ctl mmc_checker chk_i (
    .clk          (clk),
    .rst          (rst),
    .io_cycle     (io_cycle),
    .port_addr    (port_addr),
    .io_sel_n     (io_sel_n),
    .mreq         (mreq),
    .ras_n        (ras_n),
    .ipl_cs_n     (ipl_cs_n),
    .basic32_cs_n (basic32_cs_n),
    .eprom_cs_n   (eprom_cs_n),
    .sub_reset_n  (sub_reset_n),
    .sub_busreq_n (sub_busreq_n),
    .rom_state    (rom_state),
    .map_sel      (map_sel)
);

// File: tb/mapper_ctl_tb_top.sv
module mapper_ctl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       io_cycle = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0] port_addr = 8'h00, cpu_din = 8'h00;
    logic [7:0] cpu_dout;
    logic       io_sel_n;
    logic       mreq = 1'b0;
    logic [2:0] cpu_a_hi = 3'd0;
    logic       rom32_sel = 1'b0;
    logic [2:0] dram_a_hi;
    logic [3:0] ras_n;
    logic       ipl_cs_n, basic32_cs_n;
    logic [3:0] eprom_cs_n;
    logic       sub_reset_n, sub_busreq_n;
    logic       sub_ready = 1'b0, sub_ack = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    mapper_ctl dut_i (
        .clk(clk), .rst(rst), .io_cycle(io_cycle), .io_wr(io_wr), .io_rd(io_rd),
        .port_addr(port_addr), .cpu_din(cpu_din), .cpu_dout(cpu_dout),
        .io_sel_n(io_sel_n), .mreq(mreq), .cpu_a_hi(cpu_a_hi), .rom32_sel(rom32_sel),
        .dram_a_hi(dram_a_hi), .ras_n(ras_n), .ipl_cs_n(ipl_cs_n),
        .basic32_cs_n(basic32_cs_n), .eprom_cs_n(eprom_cs_n),
        .sub_reset_n(sub_reset_n), .sub_busreq_n(sub_busreq_n),
        .sub_ready(sub_ready), .sub_ack(sub_ack)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] p, input logic [7:0] d);
        @(negedge clk);
        io_cycle = 1'b1; port_addr = p; cpu_din = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_cycle = 1'b0;
        @(negedge clk);
    endtask

    task automatic io_read(input logic [7:0] p, output logic [7:0] d);
        @(negedge clk);
        io_cycle = 1'b1; io_rd = 1'b1; port_addr = p;
        #2 d = cpu_dout;
        @(negedge clk);
        io_rd = 1'b0; io_cycle = 1'b0;
    endtask

    // Expected selects from R8..R11: {ras_n, ipl, b32, eprom, bank}
    function automatic logic [12:0] model(input int map, input int sd, input int w, input logic strap);
        logic [3:0] r = 4'hF, e = 4'hF;
        logic ip = 1'b1, b = 1'b1;
        logic [2:0] bank = 3'(w);
        if (map == 0 && sd == 0 && w == 0) ip = 1'b0;
        else if (map == 0 && sd == 2 && w < 4) begin
            if (strap) b = 1'b0; else e[w] = 1'b0;
        end else if (map <= 1) r[0] = 1'b0;
        else if (map == 2) r[w < 4 ? 0 : 1] = 1'b0;
        else begin r[w < 4 ? 2 : 3] = 1'b0; bank = 3'(w) ^ 3'd4; end
        return {r, ip, b, e, bank};
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        check("R2 sub_reset_n", 32'(sub_reset_n), 0);
        check("R2 sub_busreq_n", 32'(sub_busreq_n), 1);
        io_read(8'hFD, d); check("R2 mode readback", 32'(d), 0);
        io_read(8'hFE, d); check("R2 map readback", 32'(d), 0);
    endtask

    task automatic t_port_sel();
        logic [7:0] plist [5] = '{8'hFB, 8'hFC, 8'hFE, 8'hFF, 8'h00};
        logic       exp   [5] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); io_cycle = 1'b1; port_addr = plist[i];
            #2 check("R1 io_sel_n in cycle", 32'(io_sel_n), 32'(exp[i]));
        end
        @(negedge clk); io_cycle = 1'b0; port_addr = 8'hFD;
        #2 check("R1 io_sel_n no cycle", 32'(io_sel_n), 1);
    endtask

    task automatic t_sub_reset();
        logic [7:0] d;
        io_write(8'hFD, 8'h80);
        check("R3 release sub", 32'(sub_reset_n), 1);
        io_read(8'hFD, d); check("R3 mode readback", 32'(d), 32'h80);
        io_write(8'hFD, 8'h01);
        check("R3 halt sub", 32'(sub_reset_n), 0);
        io_read(8'hFD, d); check("R3 state field", 32'(d), 32'h01);
        io_write(8'hFD, 8'h80);
    endtask

    task automatic t_busreq();
        logic [7:0] d;
        io_write(8'hFC, 8'h02);
        check("R4 request on", 32'(sub_busreq_n), 0);
        for (int k = 0; k < 4; k++) begin
            sub_ready = k[0]; sub_ack = k[1];
            io_read(8'hFC, d); check("R6 status read", 32'(d), 32'(k));
        end
        sub_ready = 1'b0; sub_ack = 1'b0;
        io_read(8'h12, d); check("R6 other port read", 32'(d), 0);
        io_write(8'hFC, 8'h00);
        check("R4 request off", 32'(sub_busreq_n), 1);
    endtask

    task automatic t_ignored();
        logic [7:0] d;
        io_write(8'hFF, 8'hFF);
        io_write(8'h7C, 8'h02);
        io_write(8'hFB, 8'h03);
        check("R5 busreq untouched", 32'(sub_busreq_n), 1);
        check("R5 reset untouched", 32'(sub_reset_n), 1);
        io_read(8'hFD, d); check("R5 mode untouched", 32'(d), 32'h80);
        io_read(8'hFE, d); check("R5 map untouched", 32'(d), 0);
        // held strobe: data change mid-pulse must not load
        @(negedge clk);
        io_cycle = 1'b1; port_addr = 8'hFE; cpu_din = 8'h01; io_wr = 1'b1;
        @(negedge clk); cpu_din = 8'h02;
        @(negedge clk); @(negedge clk);
        io_wr = 1'b0; io_cycle = 1'b0;
        io_read(8'hFE, d); check("R5 held strobe loads once", 32'(d), 1);
        io_write(8'hFE, 8'h03);
        io_read(8'hFE, d); check("R7 map write", 32'(d), 3);
        io_write(8'hFE, 8'h00);
    endtask

    task automatic t_maps();
        logic [12:0] act, exp;
        int sds [3] = '{0, 2, 1};
        for (int s = 0; s < 3; s++) begin
            io_write(8'hFD, 8'h80 | 8'(sds[s]));
            for (int m = 0; m < 4; m++) begin
                io_write(8'hFE, 8'(m));
                for (int st = 0; st < 2; st++) begin
                    for (int w = 0; w < 8; w++) begin
                        @(negedge clk);
                        mreq = 1'b1; cpu_a_hi = 3'(w); rom32_sel = st[0];
                        #2 act = {ras_n, ipl_cs_n, basic32_cs_n, eprom_cs_n,
                                  (exp_is_ram(m, sds[s], w) ? dram_a_hi : 3'(w))};
                        exp = model(m, sds[s], w, st[0]);
                        check("R8 R9 R10 R11 window decode", 32'(act), 32'(exp));
                    end
                end
            end
        end
        @(negedge clk); mreq = 1'b0;
        io_write(8'hFE, 8'h00);
        io_write(8'hFD, 8'h80);
    endtask

    function automatic logic exp_is_ram(input int m, input int sd, input int w);
        return !((m == 0 && sd == 0 && w == 0) || (m == 0 && sd == 2 && w < 4));
    endfunction

    task automatic t_idle();
        for (int w = 0; w < 8; w++) begin
            @(negedge clk); mreq = 1'b0; cpu_a_hi = 3'(w);
            #2 check("R12 idle quiet", 32'({ras_n, ipl_cs_n, basic32_cs_n, eprom_cs_n}), 32'h3FF);
        end
    endtask

    task automatic t_overlap();
        @(negedge clk);
        mreq = 1'b1; cpu_a_hi = 3'd0; rom32_sel = 1'b1;
        #2 check("R9 boot rom before switch", 32'(ipl_cs_n), 0);
        @(negedge clk);
        io_cycle = 1'b1; port_addr = 8'hFD; cpu_din = 8'h02; io_wr = 1'b1;
        #2 check("R9 boot rom until edge", 32'(ipl_cs_n), 0);
        @(negedge clk);
        io_wr = 1'b0; io_cycle = 1'b0;
        #2 check("R10 basic after edge", 32'({ipl_cs_n, basic32_cs_n}), 32'b10);
        check("R3 write 02h halts sub", 32'(sub_reset_n), 0);
        @(negedge clk); mreq = 1'b0;
    endtask

    initial begin : watchdog
        #2000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_port_sel();
        t_sub_reset();
        t_busreq();
        t_ignored();
        t_maps();
        t_idle();
        t_overlap();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule